// File: doc/BRIEF.md
# Single-Cycle Integer Core (Load/Store, Equality Branch, Four ALU Operations)

This block is a processor core that finishes one instruction on every clock edge. It supports seven instructions: word load, word store, branch-if-equal, add, subtract, AND and OR. Each instruction is fetched from a private instruction memory, which is read combinationally. The core reads two source registers and forms a sign-extended immediate. It computes a result or an address in one ALU, and it can access a separate data memory. The result is written back, and the program counter moves to the next word or to a branch target, all in the same cycle.

A loading port lets the environment fill either memory while the core is held in reset. A debug index selects one register of the file, and its contents appear combinationally on a debug output. The current program counter is also visible at the ports. Both memories are indexed by words. The index is taken from byte-address bits [AW+1:2], and the upper bits are dropped, so addresses wrap modulo the memory depth.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low, pc_o reads 0 and every register reads 0. After reset, the PC advances by 4 on every clock edge unless a branch is taken.
- R2: A branch uses opcode 1100011 and compares rs1 (bits 19:15) with rs2 (bits 24:20) by subtraction. When the zero flag is set, the next PC is the branch's own address plus the 13-bit offset {instr[31], instr[7], instr[30:25], instr[11:8], 0}, sign-extended. Otherwise the next PC is PC+4.
- R3: A register write happens on the clock edge only when the decoded write enable is high. A read of the register being written in the same cycle returns the old value.
- R4: Register 0 always reads as zero, and writes to it are discarded.
- R5: The ALU operation codes are 0000 AND, 0001 OR, 0010 add and 0110 subtract. The zero flag is high exactly when the 32-bit result is zero.
- R6: Opcode 0110011 is the register-register group. With funct3 (bits 14:12) 000, bit 30 selects add (0) or subtract (1). Funct3 111 with bit 30 = 0 selects AND, and 110 with bit 30 = 0 selects OR. Every other combination writes nothing.
- R7: A load uses opcode 0000011 and writes rd (bits 11:7) with the data word at rs1 + sext(instr[31:20]).
- R8: A store uses opcode 0100011 and writes rs2 into the data word at rs1 + sext({instr[31:25], instr[11:7]}).
- R9: Any other opcode writes neither a register nor the data memory.
- R10: A data read and a data write are never requested in the same cycle.
- R11: Both memories use byte-address bits [AW+1:2] as the word index, so an address past the top of a memory wraps to its low words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Loading-port write strobe |
| ld_dmem | input | 1 | Loading-port target: 0 instruction memory, 1 data memory |
| ld_addr | input | 32 | Loading-port byte address |
| ld_wdata | input | 32 | Loading-port write word |
| dbg_idx | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the selected register |
| pc_o | output | 32 | Current program counter |

## Verification
The bench aims at these corner cases:

- A backward branch that closes a loop. A target adder that dropped the appended zero or the sign would land on the wrong word and derail every later PC check.
- A store to offset -4 followed by a load from offset 252. A core that did not wrap the index would return stale data.
- Writes to register 0, and an instruction that reads its own destination. A design that kept the x0 write, or that forwarded the new value, would leave a wrong register at the final sweep.
- Unsupported opcodes and funct3 codes that are not decoded, each of which must leave all state untouched.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

   typedef enum logic [3:0] {
      ALU_AND = 4'b0000,
      ALU_OR  = 4'b0001,
      ALU_ADD = 4'b0010,
      ALU_SUB = 4'b0110
   } alu_op_e;

   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_ARITH  = 7'b0110011;

   typedef struct packed {
      logic    reg_we;
      logic    mem_rd;
      logic    mem_wr;
      logic    alu_imm;
      logic    wb_mem;
      logic    branch;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
   import sc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  alu_op_e      op_i,
   output logic [W-1:0] y_o,
   output logic         zero_o
);

   always_comb begin
      case (op_i)
         ALU_AND: y_o = a_i & b_i;
         ALU_OR:  y_o = a_i | b_i;
         ALU_ADD: y_o = a_i + b_i;
         ALU_SUB: y_o = a_i - b_i;
         default: y_o = '0;
      endcase
   end

   assign zero_o = (y_o == '0);

   always_comb begin
      if (op_i == ALU_SUB) AST_SUB_ZERO_EQ: assert (zero_o == (a_i == b_i)); // R5
      if (op_i == ALU_OR)  AST_OR_COVERS: assert ((y_o & a_i) == a_i); // R5
   end

endmodule

// File: rtl/sc_immgen.sv
`timescale 1ns/1ps
module sc_immgen #(
   parameter int W = 32
) (
   input  logic [31:0]  instr_i,
   output logic [W-1:0] imm_o
);

   localparam int EXT = W - 12;

   logic [11:0] field;

   always_comb begin
      case (instr_i[6:5])
         2'b00:   field = instr_i[31:20];
         2'b01:   field = {instr_i[31:25], instr_i[11:7]};
         default: field = {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8]};
      endcase
   end

   assign imm_o = {{EXT{field[11]}}, field};

   logic unused_ibits;
   assign unused_ibits = ^{instr_i[19:12], instr_i[4:0]};

   always_comb begin
      if (instr_i[6:5] == 2'b00)
         AST_LOAD_IMM: assert (imm_o[11:0] == instr_i[31:20] && imm_o[W-1] == instr_i[31]); // R7
      if (instr_i[6:5] == 2'b01)
         AST_STORE_IMM: assert (imm_o[4:0] == instr_i[11:7] && imm_o[W-1] == instr_i[31]); // R8
   end

endmodule

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
   import sc_pkg::*;
(
   input  logic [31:0] instr_i,
   output ctrl_t       ctrl_o
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic       alt;

   assign opc = instr_i[6:0];
   assign f3  = instr_i[14:12];
   assign alt = instr_i[30];

   always_comb begin
      ctrl_o        = '0;
      ctrl_o.alu_op = ALU_ADD;
      case (opc)
         OPC_LOAD: begin
            ctrl_o.reg_we  = 1'b1;
            ctrl_o.mem_rd  = 1'b1;
            ctrl_o.alu_imm = 1'b1;
            ctrl_o.wb_mem  = 1'b1;
         end
         OPC_STORE: begin
            ctrl_o.mem_wr  = 1'b1;
            ctrl_o.alu_imm = 1'b1;
         end
         OPC_BRANCH: begin
            ctrl_o.branch = 1'b1;
            ctrl_o.alu_op = ALU_SUB;
         end
         OPC_ARITH: begin
            case ({alt, f3})
               4'b0_000: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
               4'b1_000: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_SUB; end
               4'b0_111: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_AND; end
               4'b0_110: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_OR;  end
               default:  ctrl_o.reg_we = 1'b0;
            endcase
         end
         default: ctrl_o.reg_we = 1'b0;
      endcase
   end

   logic unused_dbits;
   assign unused_dbits = ^{instr_i[31], instr_i[29:15], instr_i[11:7]};

   always_comb begin
      AST_MEM_EXCL: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr)); // R10
      if (opc == OPC_BRANCH) AST_BR_NO_WRITE: assert (!ctrl_o.reg_we && !ctrl_o.mem_wr); // R2
   end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
   parameter int W       = 32,
   parameter int NREG    = 32,
   parameter int NRD     = 3,
   parameter bit ZERO_X0 = 1'b1,
   localparam int IW     = $clog2(NREG)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    we_i,
   input  logic [IW-1:0]           wa_i,
   input  logic [W-1:0]            wd_i,
   input  logic [NRD-1:0][IW-1:0]  ra_i,
   output logic [NRD-1:0][W-1:0]   rd_o
);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("sc_regfile: NREG must be a power of two, at least 2");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("sc_regfile: NRD must be at least 1");
   end

   logic [W-1:0] regs [NREG];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we_i) begin
         regs[wa_i] <= wd_i;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      if (ZERO_X0) begin : g_hard0
         assign rd_o[p] = (ra_i[p] == '0) ? '0 : regs[ra_i[p]];
      end else begin : g_plain
         assign rd_o[p] = regs[ra_i[p]];
      end
   end

   if (ZERO_X0) begin : g_x0_chk
      AST_X0_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ra_i[0] == '0) |-> (rd_o[0] == '0)); // R4
   end

   AST_RF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i) |=> ((ra_i[0] != $past(ra_i[0])) || (rd_o[0] == $past(rd_o[0])))); // R3

   AST_RF_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wa_i != '0 && ra_i[0] == wa_i) |=> ((ra_i[0] != $past(wa_i)) || (rd_o[0] == $past(wd_i)))); // R3

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
   import sc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   parameter bit ZERO_X0    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ld_we,
   input  logic        ld_dmem,
   input  logic [31:0] ld_addr,
   input  logic [31:0] ld_wdata,
   input  logic [4:0]  dbg_idx,
   output logic [31:0] dbg_data,
   output logic [31:0] pc_o
);

   localparam int IAW  = $clog2(IMEM_WORDS);
   localparam int DAW  = $clog2(DMEM_WORDS);
   localparam int NREG = 32;
   localparam int RIW  = $clog2(NREG);
   localparam int SEXT = XLEN - 13;

   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_core: XLEN must be 32");
   end
   if (IMEM_WORDS < 2 || (IMEM_WORDS & (IMEM_WORDS - 1)) != 0) begin : g_bad_imem
      $error("sc_core: IMEM_WORDS must be a power of two");
   end
   if (DMEM_WORDS < 2 || (DMEM_WORDS & (DMEM_WORDS - 1)) != 0) begin : g_bad_dmem
      $error("sc_core: DMEM_WORDS must be a power of two");
   end

   logic [XLEN-1:0] pc_q, pc_next, pc_inc, br_target;
   logic [31:0]     instr;
   ctrl_t           ctrl;
   logic [XLEN-1:0] imm, rs1_v, rs2_v, alu_b, alu_y, rdata, wb;
   logic            zero, take;

   logic [31:0] imem [IMEM_WORDS];
   logic [XLEN-1:0] dmem [DMEM_WORDS];

   // instruction fetch and loading port
   assign instr = imem[pc_q[IAW+1:2]];

   always_ff @(posedge clk) begin
      if (ld_we && !ld_dmem) imem[ld_addr[IAW+1:2]] <= ld_wdata;
   end

   sc_decode u_dec (
      .instr_i (instr),
      .ctrl_o  (ctrl)
   );

   sc_immgen #(.W(XLEN)) u_imm (
      .instr_i (instr),
      .imm_o   (imm)
   );

   logic [2:0][RIW-1:0]  rf_ra;
   logic [2:0][XLEN-1:0] rf_rd;

   assign rf_ra = {dbg_idx, instr[24:20], instr[19:15]};
   assign rs1_v = rf_rd[0];
   assign rs2_v = rf_rd[1];
   assign dbg_data = rf_rd[2];

   sc_regfile #(.W(XLEN), .NREG(NREG), .NRD(3), .ZERO_X0(ZERO_X0)) u_rf (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .we_i   (ctrl.reg_we),
      .wa_i   (instr[11:7]),
      .wd_i   (wb),
      .ra_i   (rf_ra),
      .rd_o   (rf_rd)
   );

   assign alu_b = ctrl.alu_imm ? imm : rs2_v;

   sc_alu #(.W(XLEN)) u_alu (
      .a_i    (rs1_v),
      .b_i    (alu_b),
      .op_i   (ctrl.alu_op),
      .y_o    (alu_y),
      .zero_o (zero)
   );

   // data memory
   assign rdata = ctrl.mem_rd ? dmem[alu_y[DAW+1:2]] : '0;
   assign wb    = ctrl.wb_mem ? rdata : alu_y;

   always_ff @(posedge clk) begin
      if (ld_we && ld_dmem)          dmem[ld_addr[DAW+1:2]] <= ld_wdata;
      else if (ctrl.mem_wr && rst_n) dmem[alu_y[DAW+1:2]]   <= rs2_v;
   end

   // next PC
   assign pc_inc    = pc_q + XLEN'(4);
   assign br_target = pc_q + {imm[XLEN-2:0], 1'b0};
   assign take      = ctrl.branch & zero;
   assign pc_next   = take ? br_target : pc_inc;

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_next;
   end

   assign pc_o = pc_q;

   logic unused_cbits;
   assign unused_cbits = ^{ld_addr, pc_q, alu_y, imm[XLEN-1]};

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!take) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R1

   AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> ((pc_q - $past(pc_q)) == {{SEXT{$past(instr[31])}}, $past(instr[31]), $past(instr[7]),
                                          $past(instr[30:25]), $past(instr[11:8]), 1'b0})); // R2

   AST_BR_ONLY_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.branch && rs1_v != rs2_v) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R2

   always_comb begin
      if (instr[6:0] != OPC_LOAD && instr[6:0] != OPC_STORE &&
          instr[6:0] != OPC_BRANCH && instr[6:0] != OPC_ARITH)
         AST_NOP_QUIET: assert (!ctrl.reg_we && !ctrl.mem_wr); // R9
   end

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

   localparam int WORDS = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_we = 1'b0;
   logic        ld_dmem = 1'b0;
   logic [31:0] ld_addr = '0;
   logic [31:0] ld_wdata = '0;
   logic [4:0]  dbg_idx = '0;
   logic [31:0] dbg_data;
   logic [31:0] pc_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sc_core u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_we    (ld_we),
      .ld_dmem  (ld_dmem),
      .ld_addr  (ld_addr),
      .ld_wdata (ld_wdata),
      .dbg_idx  (dbg_idx),
      .dbg_data (dbg_data),
      .pc_o     (pc_o)
   );

   // reference state
   logic [31:0] prog   [WORDS];
   logic [31:0] m_mem  [WORDS];
   logic [31:0] m_reg  [32];
   logic [31:0] m_pc;

   function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2, rs1,
                                          input logic [2:0] f3, input logic [4:0] rd);
      return {f7, rs2, rs1, f3, rd, 7'b0110011};
   endfunction
   function automatic logic [31:0] enc_lw(input logic [4:0] rd, rs1, input logic [11:0] off);
      return {off, rs1, 3'b010, rd, 7'b0000011};
   endfunction
   function automatic logic [31:0] enc_sw(input logic [4:0] rs2, rs1, input logic [11:0] off);
      return {off[11:5], rs2, rs1, 3'b010, off[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] enc_beq(input logic [4:0] rs1, rs2, input logic [12:0] off);
      return {off[12], off[10:5], rs2, rs1, 3'b000, off[4:1], off[11], 7'b1100011};
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one instruction of the reference model
   task automatic ref_step();
      logic [31:0] ins, a, b, addr, res;
      logic [4:0]  rd;
      logic        wr;
      ins = prog[(m_pc >> 2) % WORDS];
      rd  = ins[11:7];
      a   = m_reg[ins[19:15]];
      b   = m_reg[ins[24:20]];
      wr  = 1'b0;
      res = '0;
      case (ins[6:0])
         7'b0110011: begin
            wr = 1'b1;
            if (ins[14:12] == 3'b000)                  res = ins[30] ? a - b : a + b;
            else if (ins[14:12] == 3'b111 && !ins[30]) res = a & b;
            else if (ins[14:12] == 3'b110 && !ins[30]) res = a | b;
            else                                       wr = 1'b0;
         end
         7'b0000011: begin
            addr = a + {{20{ins[31]}}, ins[31:20]};
            res  = m_mem[(addr >> 2) % WORDS];
            wr   = 1'b1;
         end
         7'b0100011: begin
            addr = a + {{20{ins[31]}}, ins[31:25], ins[11:7]};
            m_mem[(addr >> 2) % WORDS] = b;
         end
         default: ;
      endcase
      if (wr && rd != 5'd0) m_reg[rd] = res;
      if (ins[6:0] == 7'b1100011 && a == b)
         m_pc = m_pc + {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
      else
         m_pc = m_pc + 32'd4;
   endtask

   task automatic run_prog(input int cycles, input string tag);
      rst_n = 1'b0;
      for (int i = 0; i < WORDS; i++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_dmem = 1'b0; ld_addr = 32'(i * 4); ld_wdata = prog[i];
      end
      for (int i = 0; i < WORDS; i++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = 32'(i * 4); ld_wdata = m_mem[i];
      end
      @(negedge clk);
      ld_we = 1'b0;
      dbg_idx = 5'd9;
      #1;
      check("R1", {tag, " pc in reset"}, pc_o, 32'd0);
      check("R1", {tag, " reg in reset"}, dbg_data, 32'd0);
      for (int r = 0; r < 32; r++) m_reg[r] = '0;
      m_pc = '0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < cycles; c++) begin
         #1;
         check("R2", {tag, " pc trace (R1)"}, pc_o, m_pc);
         ref_step();
         @(negedge clk);
      end
      for (int r = 0; r < 32; r++) begin
         dbg_idx = 5'(r);
         #1;
         if (r == 0) check("R4", {tag, " x0"}, dbg_data, 32'd0);
         else        check("R7", {tag, " reg sweep (R3 R6 R8 R9 R11)"}, dbg_data, m_reg[r]);
      end
   endtask

   initial begin
      int seed_sink;
      seed_sink = $urandom(32'd2024);
      for (int i = 0; i < WORDS; i++) begin
         prog[i]  = enc_beq(5'd0, 5'd0, 13'd0);
         m_mem[i] = 32'h1000_0000 + 32'(i * 3);
      end
      m_mem[0] = 32'hF0F0_1234;
      m_mem[1] = 32'd1;
      m_mem[2] = 32'd3;
      // directed program
      prog[0]  = enc_lw(5'd1, 5'd0, 12'd0);
      prog[1]  = enc_lw(5'd2, 5'd0, 12'd4);
      prog[2]  = enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd3);      // add  R6
      prog[3]  = enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd4);      // sub  R6
      prog[4]  = enc_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd5);      // and  R5
      prog[5]  = enc_r(7'h00, 5'd2, 5'd1, 3'b110, 5'd6);      // or   R5
      prog[6]  = enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd0);      // write x0  R4
      prog[7]  = enc_r(7'h00, 5'd1, 5'd7, 3'b000, 5'd7);      // reads own dest  R3
      prog[8]  = enc_sw(5'd3, 5'd0, 12'hFFC);                 // wraps to word 63  R11
      prog[9]  = enc_lw(5'd8, 5'd0, 12'd252);                 // R8 R11
      prog[10] = 32'h00A0_0093;                                // unsupported opcode  R9
      prog[11] = enc_r(7'h00, 5'd2, 5'd1, 3'b001, 5'd12);     // undecoded funct3  R6
      prog[12] = enc_beq(5'd1, 5'd1, 13'd8);                  // taken forward  R2
      prog[13] = enc_r(7'h00, 5'd1, 5'd1, 3'b000, 5'd9);      // skipped
      prog[14] = enc_beq(5'd1, 5'd2, 13'd8);                  // not taken  R2
      prog[15] = enc_lw(5'd10, 5'd0, 12'd8);
      prog[16] = enc_lw(5'd11, 5'd0, 12'd4);
      prog[17] = enc_r(7'h20, 5'd11, 5'd10, 3'b000, 5'd10);
      prog[18] = enc_beq(5'd10, 5'd0, 13'd8);
      prog[19] = enc_beq(5'd0, 5'd0, 13'h1FF8);               // backward  R2
      prog[20] = enc_r(7'h00, 5'd10, 5'd3, 3'b110, 5'd13);
      run_prog(40, "directed");

      // constrained random programs
      for (int p = 0; p < 6; p++) begin
         int n;
         n = 40;
         for (int i = 0; i < WORDS; i++) begin
            prog[i]  = enc_beq(5'd0, 5'd0, 13'd0);
            m_mem[i] = $urandom;
         end
         for (int i = 0; i < n - 1; i++) begin
            int kind;
            logic [4:0] rd, ra, rb;
            kind = int'($urandom % 8);
            rd = 5'($urandom % 16);
            ra = 5'($urandom % 16);
            rb = 5'($urandom % 16);
            case (kind)
               0, 1, 2, 3: begin
                  logic [2:0] f3;
                  logic [6:0] f7;
                  case ($urandom % 5)
                     0: begin f3 = 3'b000; f7 = 7'h00; end
                     1: begin f3 = 3'b000; f7 = 7'h20; end
                     2: begin f3 = 3'b111; f7 = 7'h00; end
                     3: begin f3 = 3'b110; f7 = 7'h00; end
                     default: begin f3 = 3'($urandom); f7 = 7'h20; end
                  endcase
                  prog[i] = enc_r(f7, rb, ra, f3, rd);
               end
               4: prog[i] = enc_lw(rd, ra, 12'($urandom));
               5: prog[i] = enc_sw(rb, ra, 12'($urandom));
               6: begin
                  int off;
                  off = 4 * (1 + int'($urandom % 4));
                  if (i + off / 4 > n - 1) off = 4 * (n - 1 - i);
                  prog[i] = enc_beq(ra, rb, 13'(off));
               end
               default: prog[i] = {$urandom} & 32'hFFFF_FF80 | 32'h0000_0013;
            endcase
         end
         run_prog(n + 4, "random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule